// File: doc/BRIEF.md
# Timer Wake-up Request Generator

This block sits beside a timer counter and turns its three event pulses (compare match, counter overflow and input capture) into sticky status flags. The flags stay set until the host clears them by writing ones to the status register. While the host has the system parked in idle, any flag whose per-source wake enable is set raises a wake-up line, provided a global wake enable bit is also set. The host then reads the status register to find which source woke it and clears that flag.

Idle handshaking is kept simple. The host drives an idle request. The block answers with an idle acknowledge one cycle later, but only when no enabled wake-up condition is pending. When the host leaves idle, the wake-up line drops at once and the acknowledge follows on the next cycle. A plain write strobe with address and data programs the registers, and a combinational read port returns them.

Top module: `twk_wakeup_gen`

## Requirements
- R1: After reset, all status flags, wake enables and the global enable read as 0, and both `wakeup_o` and `idle_ack_o` are 0.
- R2: An event pulse on `evt_i[k]` (bit 0 match, bit 1 overflow, bit 2 capture) sets status flag k at the next rising clock edge. The flag stays set until it is cleared, and no flag is set without its event.
- R3: A write to address 0x0 (status) clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: `wakeup_o` is combinational and equals `idle_req_i` AND global enable AND the OR over k of (flag k AND wake enable k).
- R6: A set flag whose wake enable bit is 0 does not raise `wakeup_o`.
- R7: When the global enable (bit 0 of address 0x2) is 0, `wakeup_o` stays 0 whatever the flags and wake enables hold.
- R8: `idle_ack_o` is registered. Its value after a clock edge is `idle_req_i` AND NOT pending, both sampled before that edge, where pending is the global enable AND the OR over k of (flag k AND wake enable k).
- R9: When `idle_req_i` falls, `wakeup_o` is 0 in that same cycle and `idle_ack_o` is 0 from the next cycle on.
- R10: `reg_rdata_o` is combinational from `reg_addr_i`. Address 0x0 returns the flags in bits [2:0], 0x1 the wake enables in bits [2:0], and 0x2 the global enable in bit 0. Every other bit, and every other address, reads 0.
- R11: A write to address 0x1 replaces all wake enable bits with write-data bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Single-cycle event pulses: match, overflow, capture |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for read and write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| idle_req_i | input | 1 | Idle request from the host |
| idle_ack_o | output | 1 | Idle acknowledge |
| wakeup_o | output | 1 | Wake-up request toward the host |
| status_o | output | NUM_SRC | Live view of the sticky status flags |

## Verification
Two functions can collide in one cycle: an event pulse can set a flag while a host write clears the same flag. The bench forces this collision directly on the capture flag and expects the flag to survive. The random phase also overlaps event pulses with status writes of random data many times. A bench model, in which setting takes precedence over clearing, judges every cycle by comparing the flags, the wake-up line, the acknowledge and the read data.

// File: rtl/twk_pkg.sv
package twk_pkg;
   localparam int unsigned TWK_ADDR_W = 4;
   localparam logic [TWK_ADDR_W-1:0] TWK_A_STAT = 4'h0;
   localparam logic [TWK_ADDR_W-1:0] TWK_A_WEN  = 4'h1;
   localparam logic [TWK_ADDR_W-1:0] TWK_A_CFG  = 4'h2;
   localparam int unsigned TWK_SRC_MATCH = 0;
   localparam int unsigned TWK_SRC_OVF   = 1;
   localparam int unsigned TWK_SRC_CAP   = 2;
   typedef struct packed {
      logic stat;
      logic wen;
      logic cfg;
   } twk_wsel_t;
endpackage

// File: rtl/twk_status_flags.sv
module twk_status_flags #(
   parameter int unsigned NUM_SRC = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] flag_o
);
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            flag_q <= 1'b0;
         end else if (evt_i[k]) begin
            flag_q <= 1'b1;      // set beats clear
         end else if (clr_i[k]) begin
            flag_q <= 1'b0;
         end
      end
      assign flag_o[k] = flag_q;
   end
endmodule

// File: rtl/twk_cfg_regs.sv
module twk_cfg_regs #(
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wen_we_i,
   input  logic               cfg_we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [NUM_SRC-1:0] wake_en_o,
   output logic               glb_en_o
);
   logic [NUM_SRC-1:0] wake_en_q;
   logic               glb_en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wake_en_q <= '0;
      end else if (wen_we_i) begin
         wake_en_q <= wdata_i[NUM_SRC-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         glb_en_q <= 1'b0;
      end else if (cfg_we_i) begin
         glb_en_q <= wdata_i[0];
      end
   end

   assign wake_en_o = wake_en_q;
   assign glb_en_o  = glb_en_q;
endmodule

// File: rtl/twk_idle_ctrl.sv
module twk_idle_ctrl #(
   parameter int unsigned NUM_SRC = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] flag_i,
   input  logic [NUM_SRC-1:0] wake_en_i,
   input  logic               glb_en_i,
   input  logic               idle_req_i,
   output logic               wakeup_o,
   output logic               idle_ack_o
);
   logic pending;
   logic ack_q;

   assign pending  = glb_en_i & (|(flag_i & wake_en_i));
   assign wakeup_o = idle_req_i & pending;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ack_q <= 1'b0;
      end else begin
         ack_q <= idle_req_i & ~pending;
      end
   end

   assign idle_ack_o = ack_q;
endmodule

// File: rtl/twk_wakeup_gen.sv
module twk_wakeup_gen
   import twk_pkg::*;
#(
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_SRC-1:0]    evt_i,
   input  logic                  reg_wr_i,
   input  logic [TWK_ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0]     reg_wdata_i,
   output logic [DATA_W-1:0]     reg_rdata_o,
   input  logic                  idle_req_i,
   output logic                  idle_ack_o,
   output logic                  wakeup_o,
   output logic [NUM_SRC-1:0]    status_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   if (NUM_SRC < 1 || NUM_SRC >= DATA_W) begin : g_bad_src
      $error("twk_wakeup_gen: NUM_SRC must be in 1..DATA_W-1");
   end

   twk_wsel_t          wsel;
   logic [NUM_SRC-1:0] clr;
   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] wake_en;
   logic               glb_en;

   always_comb begin
      wsel.stat = reg_wr_i && (reg_addr_i == TWK_A_STAT);
      wsel.wen  = reg_wr_i && (reg_addr_i == TWK_A_WEN);
      wsel.cfg  = reg_wr_i && (reg_addr_i == TWK_A_CFG);
   end

   assign clr = wsel.stat ? reg_wdata_i[NUM_SRC-1:0] : '0;

   twk_status_flags #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i),
      .clr_i  (clr),
      .flag_o (flags)
   );

   twk_cfg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wen_we_i  (wsel.wen),
      .cfg_we_i  (wsel.cfg),
      .wdata_i   (reg_wdata_i),
      .wake_en_o (wake_en),
      .glb_en_o  (glb_en)
   );

   twk_idle_ctrl #(.NUM_SRC(NUM_SRC)) u_idle (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flag_i     (flags),
      .wake_en_i  (wake_en),
      .glb_en_i   (glb_en),
      .idle_req_i (idle_req_i),
      .wakeup_o   (wakeup_o),
      .idle_ack_o (idle_ack_o)
   );

   always_comb begin
      unique case (reg_addr_i)
         TWK_A_STAT: reg_rdata_o = {{PAD_W{1'b0}}, flags};
         TWK_A_WEN:  reg_rdata_o = {{PAD_W{1'b0}}, wake_en};
         TWK_A_CFG:  reg_rdata_o = {{(DATA_W-1){1'b0}}, glb_en};
         default:    reg_rdata_o = '0;
      endcase
   end

   assign status_o = flags;
endmodule

// File: rtl/twk_wakeup_chk.sv
module twk_wakeup_chk
   import twk_pkg::*;
#(
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned DATA_W  = 32
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic [NUM_SRC-1:0]    evt_i,
   input logic                  reg_wr_i,
   input logic [TWK_ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0]     reg_wdata_i,
   input logic                  idle_req_i,
   input logic                  idle_ack_o,
   input logic                  wakeup_o,
   input logic [NUM_SRC-1:0]    status_o,
   input logic [NUM_SRC-1:0]    wake_en_i,
   input logic                  glb_en_i
);
   logic [NUM_SRC-1:0] clr_req;
   assign clr_req = (reg_wr_i && reg_addr_i == TWK_A_STAT) ? reg_wdata_i[NUM_SRC-1:0] : '0;

   p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

   p_no_spurious_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((status_o & ~$past(status_o) & ~$past(evt_i)) == '0));

   p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_req & ~evt_i) != '0) |=> ((status_o & $past(clr_req & ~evt_i)) == '0));

   p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (($past(status_o) & ~$past(clr_req) & ~status_o) == '0));

   p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_req & evt_i) != '0) |=> ((status_o & $past(clr_req & evt_i)) == $past(clr_req & evt_i)));

   p_wake_needs_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wakeup_o |-> idle_req_i);

   p_wake_needs_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wakeup_o |-> ((status_o & wake_en_i) != '0));

   p_wake_needs_glb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wakeup_o |-> glb_en_i);

   p_ack_follows_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_ack_o |-> $past(idle_req_i));

   p_ack_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(idle_req_i) |=> !idle_ack_o);
endmodule

bind twk_wakeup_gen twk_wakeup_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .evt_i       (evt_i),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .idle_req_i  (idle_req_i),
   .idle_ack_o  (idle_ack_o),
   .wakeup_o    (wakeup_o),
   .status_o    (status_o),
   .wake_en_i   (wake_en),
   .glb_en_i    (glb_en)
);

// File: tb/twk_wakeup_gen_tb.sv
module twk_wakeup_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 3;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic [NS-1:0] evt_i = '0;
   logic          reg_wr_i = 1'b0;
   logic [3:0]    reg_addr_i = '0;
   logic [DW-1:0] reg_wdata_i = '0;
   logic [DW-1:0] reg_rdata_o;
   logic          idle_req_i = 1'b0;
   logic          idle_ack_o;
   logic          wakeup_o;
   logic [NS-1:0] status_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [NS-1:0] m_stat = '0;
   logic [NS-1:0] m_wen  = '0;
   logic          m_glb  = 1'b0;
   logic          m_ack  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   twk_wakeup_gen #(.NUM_SRC(NS), .DATA_W(DW)) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .evt_i       (evt_i),
      .reg_wr_i    (reg_wr_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .idle_req_i  (idle_req_i),
      .idle_ack_o  (idle_ack_o),
      .wakeup_o    (wakeup_o),
      .status_o    (status_o)
   );

   function automatic logic pend();
      return m_glb & (|(m_stat & m_wen));
   endfunction

   function automatic logic exp_wake(input logic idle);
      return idle & pend();
   endfunction

   function automatic logic [DW-1:0] exp_rd(input logic [3:0] a);
      case (a)
         4'h0:    return {{(DW-NS){1'b0}}, m_stat};
         4'h1:    return {{(DW-NS){1'b0}}, m_wen};
         4'h2:    return {{(DW-1){1'b0}}, m_glb};
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // drive at the falling edge, then compare against the model
   task automatic drv(input logic [NS-1:0] e, input logic w, input logic [3:0] a,
                      input logic [DW-1:0] d, input logic idle);
      @(negedge clk);
      evt_i = e; reg_wr_i = w; reg_addr_i = a; reg_wdata_i = d; idle_req_i = idle;
      #1;
      chk("R2 status", {{(DW-NS){1'b0}}, status_o}, {{(DW-NS){1'b0}}, m_stat});
      chk("R5 wakeup", {{(DW-1){1'b0}}, wakeup_o}, {{(DW-1){1'b0}}, exp_wake(idle)});
      chk("R8 idle_ack", {{(DW-1){1'b0}}, idle_ack_o}, {{(DW-1){1'b0}}, m_ack});
      chk("R10 rdata", reg_rdata_o, exp_rd(a));
   endtask

   // rising edge: advance the model with the values driven
   task automatic tick();
      logic [NS-1:0] clr;
      @(posedge clk);
      clr   = (reg_wr_i && reg_addr_i == 4'h0) ? reg_wdata_i[NS-1:0] : '0;
      m_ack = idle_req_i & ~pend();
      if (reg_wr_i && reg_addr_i == 4'h1) m_wen = reg_wdata_i[NS-1:0];
      if (reg_wr_i && reg_addr_i == 4'h2) m_glb = reg_wdata_i[0];
      m_stat = (m_stat & ~clr) | evt_i;
   endtask

   task automatic cyc(input logic [NS-1:0] e, input logic w, input logic [3:0] a,
                      input logic [DW-1:0] d, input logic idle);
      drv(e, w, a, d, idle);
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic idle;
      void'($urandom(32'h5eed_1234));
      // R1: reset state
      repeat (2) @(negedge clk);
      reg_addr_i = 4'h1; #1;
      chk("R1 wen", reg_rdata_o, '0);
      reg_addr_i = 4'h2; #1;
      chk("R1 glb", reg_rdata_o, '0);
      chk("R1 status", {{(DW-NS){1'b0}}, status_o}, '0);
      chk("R1 wakeup", {{(DW-1){1'b0}}, wakeup_o}, '0);
      chk("R1 ack", {{(DW-1){1'b0}}, idle_ack_o}, '0);
      @(negedge clk); rst_ni = 1'b1;

      cyc(3'b000, 1'b1, 4'h1, 32'h7, 1'b0);          // all wake enables
      cyc(3'b000, 1'b1, 4'h2, 32'h0, 1'b0);          // global off
      cyc(3'b001, 1'b0, 4'h0, 32'h0, 1'b1);          // match event, idle
      drv(3'b000, 1'b0, 4'h1, 32'h0, 1'b1);
      chk("R7 wake blocked by global", {{(DW-1){1'b0}}, wakeup_o}, '0);
      chk("R11 wen readback", reg_rdata_o, 32'h7);
      chk("R2 match flag", {{(DW-NS){1'b0}}, status_o}, 32'h1);
      tick();
      cyc(3'b000, 1'b1, 4'h2, 32'h1, 1'b1);          // global on
      drv(3'b000, 1'b0, 4'h0, 32'h0, 1'b1);
      chk("R5 wake up", {{(DW-1){1'b0}}, wakeup_o}, 32'h1);
      tick();
      drv(3'b000, 1'b0, 4'h0, 32'h0, 1'b0);
      chk("R9 wake drops with idle", {{(DW-1){1'b0}}, wakeup_o}, '0);
      tick();
      cyc(3'b000, 1'b1, 4'h0, 32'h1, 1'b1);          // clear match
      drv(3'b000, 1'b0, 4'h0, 32'h0, 1'b1);
      chk("R3 cleared", {{(DW-NS){1'b0}}, status_o}, '0);
      tick();
      drv(3'b000, 1'b0, 4'h0, 32'h0, 1'b1);
      chk("R8 ack raised", {{(DW-1){1'b0}}, idle_ack_o}, 32'h1);
      tick();
      drv(3'b000, 1'b0, 4'h0, 32'h0, 1'b0);
      chk("R9 ack lags one cycle", {{(DW-1){1'b0}}, idle_ack_o}, 32'h1);
      tick();
      drv(3'b000, 1'b0, 4'h0, 32'h0, 1'b0);
      chk("R9 ack dropped", {{(DW-1){1'b0}}, idle_ack_o}, '0);
      tick();
      cyc(3'b110, 1'b0, 4'h0, 32'h0, 1'b0);
      cyc(3'b000, 1'b1, 4'h0, 32'h0, 1'b0);          // write zeros
      drv(3'b000, 1'b0, 4'h0, 32'h0, 1'b0);
      chk("R3 zero write keeps", reg_rdata_o, 32'h6);
      tick();
      cyc(3'b100, 1'b1, 4'h0, 32'h4, 1'b0);          // set and clear collide
      drv(3'b000, 1'b0, 4'h0, 32'h0, 1'b0);
      chk("R4 set wins", reg_rdata_o, 32'h6);
      tick();
      cyc(3'b000, 1'b1, 4'h1, 32'h1, 1'b1);          // only match enabled
      drv(3'b000, 1'b0, 4'h3, 32'h0, 1'b1);
      chk("R6 disabled source quiet", {{(DW-1){1'b0}}, wakeup_o}, '0);
      chk("R10 unmapped reads zero", reg_rdata_o, '0);
      tick();

      // constrained random phase
      idle = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         logic [NS-1:0] e;
         logic          w;
         for (int k = 0; k < NS; k++) e[k] = ($urandom % 6) == 0;
         w = ($urandom % 4) == 0;
         if (($urandom % 8) == 0) idle = ~idle;
         cyc(e, w, 4'($urandom % 4), $urandom, idle);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule